// File: doc/BRIEF.md
# Seconds counter with alarm

This block is a real-time clock peripheral that sits on a simple 32-bit register bus with single-cycle transfers: select, write strobe, byte address, write data and combinational read data. A prescaler divides the system clock by `CLK_HZ` into a one-cycle tick once per second. Each tick advances a free-running 32-bit seconds counter, which wraps modulo 2^32. Software writes an absolute time into the load register and sets a match value. When the counter equals the match value, a sticky raw alarm flag is raised. A one-bit mask gates that flag onto a level-sensitive interrupt output. The top eight words of the 4 KB window return fixed identification bytes.

The alarm flag is held by a two-state machine. In `AL_QUIET` no alarm is pending. In `AL_RAISED` the flag reads as 1. The transition `QUIET->RAISED` is taken on a hit. A hit is an update, whether a tick, a load write or a match write, after which the counter equals the match value. The transition `RAISED->QUIET` is taken on any write to the clear register, but only when no hit occurs in the same cycle. In every other case the state holds.

Bus decode sorts each address into one of ten selections: count, match, load, control, mask, raw status, masked status, clear, identification or none. The read path and the write strobes are driven from that selection. All state changes on the rising clock edge. Reset is synchronous and active low.

Top module: `secs_rtc`

## Requirements
- R1: After reset the count (0x00), match (0x04), load (0x08), mask (0x10) and raw status (0x14) all read 0, and `irq` is low.
- R2: The count increments by one on every tick. A tick comes every `CLK_HZ` clock cycles. The count wraps from 0xFFFFFFFF to 0.
- R3: A write to 0x08 sets the count to the written value from the next cycle onward. The written value reads back at 0x08. The prescaler restarts, so the next increment follows `CLK_HZ` cycles after the write edge.
- R4: A write to 0x04 stores the match value, which reads back at 0x04. When a tick brings the count to exactly the match value, bit 0 of 0x14 becomes 1.
- R5: A write to 0x04 of a value equal to the count sets bit 0 of 0x14 at once. So does a write to 0x08 of a value equal to the stored match value.
- R6: Only bit 0 of a write to 0x10 is kept. Reads of 0x10 return that bit, with bits [31:1] zero.
- R7: Bit 0 of 0x18 and the `irq` output both equal the raw flag AND the mask bit.
- R8: Any write to 0x1C clears the raw flag, whatever the data. If a hit occurs in the same cycle as the clear, the flag is set instead.
- R9: 0x0C always reads 1. Writes to it change nothing.
- R10: Aligned reads at 0xFE0 to 0xFFC return, in address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in bits [7:0], with the upper bits zero.
- R11: Writes to 0x00, 0x14, 0x18 and the identification words change no state. Reads return 0 at 0x1C, at unaligned addresses and at every unmapped address.
- R12: Once set, the raw flag stays set until it is cleared, even as the count moves past the match value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Transfer select |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| irq | output | 1 | Level interrupt, raw alarm AND mask |

## Verification
The assertions assume that all bus inputs change only between clock edges and that each write lasts exactly one cycle. They also assume that `CLK_HZ` is at least 2, so that two ticks are never adjacent. The stimulus drives every input on the falling edge and holds select high for a single cycle per write. The random mix has match and load values drawn close to the live count, so that hits, wraps and clear-versus-hit collisions all occur within the kept rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [3:0] {
        SEL_COUNT,
        SEL_MATCH,
        SEL_LOAD,
        SEL_CTRL,
        SEL_MASK,
        SEL_RAW,
        SEL_MIS,
        SEL_CLR,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        AL_QUIET  = 1'b0,
        AL_RAISED = 1'b1
    } alarm_st_e;

    // Address decode: word registers in the lowest 32 bytes, id words in the top 32.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[ADDR_W-1:5] == '1) begin
                s = SEL_ID;
            end else if (a[ADDR_W-1:5] == '0) begin
                unique case (a[4:2])
                    3'd0: s = SEL_COUNT;
                    3'd1: s = SEL_MATCH;
                    3'd2: s = SEL_LOAD;
                    3'd3: s = SEL_CTRL;
                    3'd4: s = SEL_MASK;
                    3'd5: s = SEL_RAW;
                    3'd6: s = SEL_MIS;
                    3'd7: s = SEL_CLR;
                endcase
            end
        end
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

    // R3
    presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    input  logic         match_we,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] count,
    output logic [W-1:0] match,
    output logic         hit
);

    logic [W-1:0] cnt_nx;
    logic [W-1:0] match_nx;

    always_comb begin
        if (load_we) begin
            cnt_nx = load_val;
        end else if (tick) begin
            cnt_nx = count + 1'b1;
        end else begin
            cnt_nx = count;
        end
        match_nx = match_we ? match_val : match;
        hit      = (tick || load_we || match_we) && (cnt_nx == match_nx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            match <= '0;
        end else begin
            count <= cnt_nx;
            match <= match_nx;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we) |=> count == W'($past(count) + 1'b1));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count == $past(load_val));

    // R4
    match_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_we |=> $stable(match));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic raw
);

    alarm_st_e st_q;
    alarm_st_e st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            AL_QUIET:  if (hit) st_nx = AL_RAISED;
            AL_RAISED: if (clear && !hit) st_nx = AL_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= AL_QUIET;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        raw = (st_q == AL_RAISED);
    end

    // R4
    alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);

    // R8
    alarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !hit) |=> !raw);

    // R12
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clear) |=> raw);

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);

    reg_sel_e          sel;
    logic              bus_wr;
    logic              bus_rd;
    logic              wr_load;
    logic              wr_match;
    logic              wr_mask;
    logic              wr_clr;
    logic              tick;
    logic              hit;
    logic              raw;
    logic              mask_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] match_q;

    always_comb begin
        sel      = decode_addr(paddr);
        bus_wr   = psel && pwrite;
        bus_rd   = psel && !pwrite;
        wr_load  = bus_wr && (sel == SEL_LOAD);
        wr_match = bus_wr && (sel == SEL_MATCH);
        wr_mask  = bus_wr && (sel == SEL_MASK);
        wr_clr   = bus_wr && (sel == SEL_CLR);
    end

    rtc_prescale #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_load),
        .tick    (tick)
    );

    rtc_count #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_we   (wr_load),
        .load_val  (pwdata),
        .match_we  (wr_match),
        .match_val (pwdata),
        .count     (count_q),
        .match     (match_q),
        .hit       (hit)
    );

    rtc_alarm u_al (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clear (wr_clr),
        .raw   (raw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            mask_q <= 1'b0;
        end else begin
            if (wr_load) load_q <= pwdata;
            if (wr_mask) mask_q <= pwdata[0];
        end
    end

    always_comb begin
        prdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_COUNT: prdata = count_q;
                SEL_MATCH: prdata = match_q;
                SEL_LOAD:  prdata = load_q;
                SEL_CTRL:  prdata = DATA_W'(1);
                SEL_MASK:  prdata = DATA_W'(mask_q);
                SEL_RAW:   prdata = DATA_W'(raw);
                SEL_MIS:   prdata = DATA_W'(raw && mask_q);
                SEL_ID:    prdata = DATA_W'(id_byte(paddr[4:2]));
                SEL_CLR,
                SEL_NONE:  prdata = '0;
            endcase
        end
    end

    assign irq = raw && mask_q;

    // R6
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !pwdata[0]) |=> !irq);

    // R3
    load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_load |=> $stable(load_q));

    // R11
    ro_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_COUNT && !tick) |=> $stable(count_q));

endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;

    localparam int HZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    secs_rtc #(.CLK_HZ(HZ), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    // Reference model from the requirements
    logic [31:0] m_cnt, m_match, m_load;
    logic        m_mask, m_raw;
    int          m_pre;

    always @(posedge clk) begin
        logic        wr, ld, mw, cl, tk, hv;
        logic [31:0] nc, nm;
        if (!rst_n) begin
            m_cnt <= 0; m_match <= 0; m_load <= 0; m_mask <= 0; m_raw <= 0; m_pre <= 0;
        end else begin
            wr = psel && pwrite;
            ld = wr && paddr == 12'h008;
            mw = wr && paddr == 12'h004;
            cl = wr && paddr == 12'h01C;
            tk = (m_pre == HZ - 1);
            nc = ld ? pwdata : (tk ? m_cnt + 32'd1 : m_cnt);
            nm = mw ? pwdata : m_match;
            hv = (ld || mw || tk) && nc == nm;
            m_cnt   <= nc;
            m_match <= nm;
            m_pre   <= (ld || tk) ? 0 : m_pre + 1;
            if (ld) m_load <= pwdata;
            if (wr && paddr == 12'h010) m_mask <= pwdata[0];
            if (hv) m_raw <= 1'b1;
            else if (cl) m_raw <= 1'b0;
        end
    end

    function automatic logic [7:0] id_tab(input int i);
        case (i)
            0: return 8'h31; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
            4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a[11:5] == 7'h7F) return {24'h0, id_tab(int'(a[4:2]))};
        if (a[11:5] != 7'h00) return 0;
        case (a[4:2])
            3'd0: return m_cnt;
            3'd1: return m_match;
            3'd2: return m_load;
            3'd3: return 32'd1;
            3'd4: return {31'h0, m_mask};
            3'd5: return {31'h0, m_raw};
            3'd6: return {31'h0, m_raw & m_mask};
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h000: return "R2";
            12'h004: return "R4";
            12'h008: return "R3";
            12'h00C: return "R9";
            12'h010: return "R6";
            12'h014: return "R12";
            12'h018: return "R7";
            default: return (a[11:5] == 7'h7F && a[1:0] == 0) ? "R10" : "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [11:0] pick_addr();
        int k;
        k = int'($urandom % 15);
        case (k)
            0: return 12'h000; 1: return 12'h004; 2: return 12'h008; 3: return 12'h00C;
            4: return 12'h010; 5: return 12'h014; 6: return 12'h018; 7: return 12'h01C;
            8: return 12'h004; 9: return 12'h008; 10: return 12'h01C;
            11: return 12'h020; 12: return 12'h402; 13: return 12'hFE0 + 12'(4 * ($urandom % 8));
            default: return 12'h7F0;
        endcase
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 count", 12'h000, 32'h0);
        rdchk("R1 match", 12'h004, 32'h0);
        rdchk("R1 load", 12'h008, 32'h0);
        rdchk("R1 mask", 12'h010, 32'h0);
        rdchk("R1 raw", 12'h014, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rdchk("R9 ctrl", 12'h00C, 32'h1);

        // R10 identification words
        for (int i = 0; i < 8; i++)
            rdchk("R10 id", 12'hFE0 + 12'(4 * i), {24'h0, id_tab(i)});

        // R11 zero reads
        rdchk("R11 clr read", 12'h01C, 32'h0);
        rdchk("R11 unmapped", 12'h020, 32'h0);
        rdchk("R11 unaligned", 12'h005, 32'h0);

        // R6 mask keeps bit 0 only
        wr(12'h010, 32'hFFFF_FFFE);
        rdchk("R6 mask even", 12'h010, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        rdchk("R6 mask all", 12'h010, 32'h1);
        wr(12'h010, 32'h0);

        // R9 control ignores writes
        wr(12'h00C, 32'h0);
        rdchk("R9 ctrl after write", 12'h00C, 32'h1);

        // R3 load and prescaler restart
        wr(12'h008, 32'd100);
        rdchk("R3 load now", 12'h000, 32'd100);
        rdchk("R3 load readback", 12'h008, 32'd100);
        repeat (HZ - 1) @(negedge clk);
        rdchk("R3 before tick", 12'h000, 32'd100);
        @(negedge clk);
        rdchk("R3 after full second", 12'h000, 32'd101);

        // R2 wrap
        wr(12'h008, 32'hFFFF_FFFF);
        repeat (HZ - 1) @(negedge clk);
        rdchk("R2 pre-wrap", 12'h000, 32'hFFFF_FFFF);
        @(negedge clk);
        rdchk("R2 wrap", 12'h000, 32'h0);

        // R4 tick hit, R7 masking, R12 hold, R8 clear
        wr(12'h010, 32'h1);
        wr(12'h008, 32'd10);
        wr(12'h004, 32'd12);
        wr(12'h01C, 32'h0);
        rdchk("R4 match readback", 12'h004, 32'd12);
        repeat (12) @(negedge clk);
        rdchk("R4 not yet", 12'h014, 32'h0);
        repeat (2) @(negedge clk);
        rdchk("R4 count at match", 12'h000, 32'd12);
        rdchk("R4 raw set", 12'h014, 32'h1);
        rdchk("R7 masked", 12'h018, 32'h1);
        chk("R7 irq", {31'h0, irq}, 32'h1);
        repeat (20) @(negedge clk);
        rdchk("R12 raw held", 12'h014, 32'h1);
        wr(12'h01C, 32'h0);
        rdchk("R8 cleared", 12'h014, 32'h0);
        chk("R8 irq low", {31'h0, irq}, 32'h0);

        // R5 immediate hit by match write and by load write
        wr(12'h008, 32'd200);
        wr(12'h004, 32'd200);
        rdchk("R5 match eq count", 12'h014, 32'h1);
        wr(12'h01C, 32'hDEAD_BEEF);
        rdchk("R8 any data", 12'h014, 32'h0);
        wr(12'h004, 32'd300);
        wr(12'h008, 32'd300);
        rdchk("R5 load eq match", 12'h014, 32'h1);
        wr(12'h010, 32'h0);
        rdchk("R7 masked off", 12'h018, 32'h0);
        chk("R7 irq off", {31'h0, irq}, 32'h0);
        rdchk("R7 raw kept", 12'h014, 32'h1);

        // R11 read-only writes ignored
        wr(12'h014, 32'h0);
        rdchk("R11 raw write", 12'h014, 32'h1);
        wr(12'h018, 32'h0);
        rdchk("R11 mis write", 12'h014, 32'h1);
        wr(12'h000, 32'd5);
        rdchk("R11 count write", 12'h000, 32'd300);
        wr(12'hFE0, 32'h0);
        rdchk("R11 id write", 12'hFE0, 32'h31);

        // R8 set wins over clear in the same cycle
        wr(12'h01C, 32'h0);
        wr(12'h004, 32'd51);
        wr(12'h008, 32'd50);
        repeat (HZ - 1) @(negedge clk);
        wr(12'h01C, 32'h1);
        rdchk("R8 set wins count", 12'h000, 32'd51);
        rdchk("R8 set wins", 12'h014, 32'h1);

        // Random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            a = pick_addr();
            if ($urandom % 2 == 0) begin
                if (a == 12'h004) d = m_cnt + ($urandom % 3);
                else if (a == 12'h008) d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : m_match - ($urandom % 2);
                else d = $urandom;
                wr(a, d);
            end else begin
                rd(a, d);
                chk({tag_of(a), " random"}, d, model_rd(a));
            end
            chk("R7 random irq", {31'h0, irq}, {31'h0, m_raw & m_mask});
            repeat ($urandom % 3) @(negedge clk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule